// File: doc/BRIEF.md
# Store-Bypass-Aware Load Issue Gate

This block sits in the load issue path of one hardware thread. It decides whether a ready load may issue while stores older than it still lack a resolved address. A small store table keeps a valid flag and an address-known flag for each in-flight store. Each load slot takes a snapshot of the stores that were valid when the load was dispatched, and those stores are the ones older than the load.

A load may issue speculatively past its unresolved older stores when three things hold together. The mitigation control bit must be clear. The secure-mode input must be low. The slot's one-bit alias predictor must say "no alias". If any of these three does not hold, the load waits until every store in its snapshot has a known address.

When a store resolves to an address in the same 8-byte granule as a load that already issued speculatively, and that store is in the load's snapshot, the gate raises a one-cycle replay pulse that carries the slot index. The slot then returns to the not-issued state and its predictor bit is set to "alias".

Top module: `spec_load_gate`

## Requirements
- R1: After reset the control bit is 0, replay_v is 0, every load slot is empty (issue_ok is 0 for any request) and every predictor bit reads "no alias".
- R2: issue_ok is 1 only when the requested slot is live and not yet issued. With control bit 0, secure_mode 0 and predictor bit 0, such a slot gets issue_ok 1 even while stores in its snapshot are unresolved.
- R3: With control bit 1, issue_ok is 0 while any store in the slot's snapshot is valid with an unknown address. Once all of those stores have known addresses, issue_ok is 1.
- R4: While secure_mode is 1, the gate blocks exactly as in R3, whatever the value of the control bit.
- R5: A slot's snapshot holds the stores that are valid at dispatch and not retired in that same cycle. A store allocated in the dispatch cycle or later never blocks that load and never replays it.
- R6: Suppose a store resolves at clock edge k, and a load that has issued holds that store in its snapshot with an overlapping address. Then replay_v is 1 in the cycle after edge k, with replay_slot equal to the load's slot, for one cycle. The slot is then no longer issued and may issue again.
- R7: Overlap compares address bits [AW-1:3]. Addresses that differ only in bits [2:0] overlap. Addresses that differ in any higher bit do not.
- R8: Once a slot has been replayed, its predictor bit is 1 until reset, and that slot waits as in R3 whatever the control bit and secure_mode are.
- R9: When several slots have replays pending, the lowest slot index is reported first, one slot per cycle.
- R10: Retiring a store removes it from every snapshot. If the store-table entry is then reallocated, it does not block loads dispatched before the reallocation.
- R11: A load that issues in the same cycle in which an overlapping older store resolves is replayed in the next cycle.
- R12: When ctl_we is 1 at a clock edge, ctl_wd is written into the control bit, and requests from the next cycle on see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the mitigation control bit |
| ctl_wd | input | 1 | Value written to the control bit |
| secure_mode | input | 1 | Forces in-order-address behaviour while high |
| st_alloc_v | input | 1 | Allocate a store-table entry |
| st_alloc_idx | input | $clog2(SQ_N) | Entry being allocated |
| st_res_v | input | 1 | A store address becomes known |
| st_res_idx | input | $clog2(SQ_N) | Entry whose address resolves |
| st_res_addr | input | AW | Resolved store address |
| st_ret_v | input | 1 | Retire or squash a store entry |
| st_ret_idx | input | $clog2(SQ_N) | Entry leaving the table |
| ld_disp_v | input | 1 | Dispatch a load into a slot |
| ld_disp_slot | input | $clog2(LD_N) | Slot being filled |
| ld_req_v | input | 1 | A load asks to issue |
| ld_req_slot | input | $clog2(LD_N) | Slot asking to issue |
| ld_req_addr | input | AW | Address of the requesting load |
| ld_free_v | input | 1 | Release a load slot |
| ld_free_slot | input | $clog2(LD_N) | Slot released |
| issue_ok | output | 1 | The request this cycle may issue |
| replay_v | output | 1 | One-cycle replay pulse |
| replay_slot | output | $clog2(LD_N) | Slot to be replayed |

## Verification
The bench uses the default sizes: eight store entries, four load slots, 32-bit addresses and an 8-byte overlap granule. Random store addresses are drawn from only eight granules, so late aliases and several replays pending at once come up often. Because every store entry and every load slot can be busy at the same moment, the bench reaches snapshot clearing on retire, reallocation of a retired entry and lowest-slot-first replay ordering. Periodic resets clear the sticky predictor bits, which keeps speculative issue within reach during long random runs.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

   // Reason attached to a request: free to speculate, or which source forces it to wait
   typedef enum logic [1:0] {
      GATE_FREE      = 2'd0,
      GATE_WAIT_CTL  = 2'd1,
      GATE_WAIT_SEC  = 2'd2,
      GATE_WAIT_PRED = 2'd3
   } gate_why_e;

endpackage

// File: rtl/sbg_store_table.sv
module sbg_store_table #(
   parameter int SQ_N = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_v,
   input  logic [$clog2(SQ_N)-1:0] alloc_idx,
   input  logic                    res_v,
   input  logic [$clog2(SQ_N)-1:0] res_idx,
   input  logic                    ret_v,
   input  logic [$clog2(SQ_N)-1:0] ret_idx,
   output logic [SQ_N-1:0]         st_valid,
   output logic [SQ_N-1:0]         st_known,
   output logic [SQ_N-1:0]         ret_mask
);

   for (genvar s = 0; s < SQ_N; s++) begin : g_ent
      localparam logic [$clog2(SQ_N)-1:0] MY = s[$clog2(SQ_N)-1:0];

      assign ret_mask[s] = ret_v && (ret_idx == MY);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_valid[s] <= 1'b0;
            st_known[s] <= 1'b0;
         end else if (ret_mask[s]) begin
            st_valid[s] <= 1'b0;
            st_known[s] <= 1'b0;
         end else if (alloc_v && alloc_idx == MY) begin
            st_valid[s] <= 1'b1;
            st_known[s] <= 1'b0;
         end else if (res_v && res_idx == MY) begin
            st_known[s] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/sbg_alias_match.sv
module sbg_alias_match #(
   parameter int LD_N = 4,
   parameter int AW   = 32,
   parameter int GRAN = 3
) (
   input  logic                   res_v,
   input  logic [AW-1:0]          res_addr,
   input  logic [LD_N-1:0]        live,
   input  logic [LD_N-1:0]        issued,
   input  logic [LD_N-1:0]        fire,
   input  logic [LD_N-1:0]        snap_hit,
   input  logic [LD_N-1:0][AW-1:0] laddr,
   input  logic [AW-1:0]          req_addr,
   output logic [LD_N-1:0]        hit
);

   localparam logic [AW-1:0] GMASK = ~((AW'(1) << GRAN) - AW'(1));

   logic [LD_N-1:0] old_eq;
   logic            new_eq;

   if (GRAN == 0) begin : g_exact
      assign new_eq = (req_addr == res_addr);
      for (genvar l = 0; l < LD_N; l++) begin : g_cmp
         assign old_eq[l] = (laddr[l] == res_addr);
      end
   end else begin : g_granule
      assign new_eq = ((req_addr ^ res_addr) & GMASK) == '0;
      for (genvar l = 0; l < LD_N; l++) begin : g_cmp
         assign old_eq[l] = ((laddr[l] ^ res_addr) & GMASK) == '0;
      end
   end

   for (genvar l = 0; l < LD_N; l++) begin : g_hit
      assign hit[l] = res_v && snap_hit[l] && live[l] &&
                      ((issued[l] && old_eq[l]) || (fire[l] && new_eq));
   end

endmodule

// File: rtl/sbg_replay_pick.sv
module sbg_replay_pick #(
   parameter int LD_N = 4
) (
   input  logic [LD_N-1:0]         pend,
   output logic                    valid,
   output logic [$clog2(LD_N)-1:0] idx,
   output logic [LD_N-1:0]         clr
);

   localparam int LIW = $clog2(LD_N);

   always_comb begin
      valid = |pend;
      idx   = '0;
      for (int i = LD_N - 1; i >= 0; i--) begin
         if (pend[i]) idx = LIW'(i);
      end
      clr = '0;
      if (valid) clr[idx] = 1'b1;
   end

endmodule

// File: rtl/spec_load_gate.sv
module spec_load_gate #(
   parameter int SQ_N = 8,
   parameter int LD_N = 4,
   parameter int AW   = 32,
   parameter int GRAN = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ctl_we,
   input  logic                    ctl_wd,
   input  logic                    secure_mode,
   input  logic                    st_alloc_v,
   input  logic [$clog2(SQ_N)-1:0] st_alloc_idx,
   input  logic                    st_res_v,
   input  logic [$clog2(SQ_N)-1:0] st_res_idx,
   input  logic [AW-1:0]           st_res_addr,
   input  logic                    st_ret_v,
   input  logic [$clog2(SQ_N)-1:0] st_ret_idx,
   input  logic                    ld_disp_v,
   input  logic [$clog2(LD_N)-1:0] ld_disp_slot,
   input  logic                    ld_req_v,
   input  logic [$clog2(LD_N)-1:0] ld_req_slot,
   input  logic [AW-1:0]           ld_req_addr,
   input  logic                    ld_free_v,
   input  logic [$clog2(LD_N)-1:0] ld_free_slot,
   output logic                    issue_ok,
   output logic                    replay_v,
   output logic [$clog2(LD_N)-1:0] replay_slot
);
   import sbg_pkg::*;

   localparam int LIW = $clog2(LD_N);

   if (SQ_N < 2 || LD_N < 2) begin : g_bad_size
      $error("spec_load_gate: SQ_N and LD_N must both be at least 2");
   end
   if (GRAN >= AW) begin : g_bad_gran
      $error("spec_load_gate: GRAN must be below AW");
   end

   // Mitigation control bit
   logic ctl_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= 1'b0;
      else if (ctl_we) ctl_q <= ctl_wd;
   end

   // Store table
   logic [SQ_N-1:0] st_valid, st_known, ret_mask;
   sbg_store_table #(.SQ_N(SQ_N)) u_st (
      .clk(clk), .rst_n(rst_n),
      .alloc_v(st_alloc_v), .alloc_idx(st_alloc_idx),
      .res_v(st_res_v), .res_idx(st_res_idx),
      .ret_v(st_ret_v), .ret_idx(st_ret_idx),
      .st_valid(st_valid), .st_known(st_known), .ret_mask(ret_mask)
   );

   // Load slot state
   logic [LD_N-1:0]           live_q, issued_q, pred_q, pend_q;
   logic [LD_N-1:0][SQ_N-1:0] snap_q;
   logic [LD_N-1:0][AW-1:0]   laddr_q;

   logic [LD_N-1:0] unres, snap_hit, fire, hit, clr;
   logic            unres_sel;
   gate_why_e       why;

   for (genvar l = 0; l < LD_N; l++) begin : g_unres
      assign unres[l]    = |(snap_q[l] & st_valid & ~st_known);
      assign snap_hit[l] = snap_q[l][st_res_idx];
   end

   assign unres_sel = unres[ld_req_slot];

   always_comb begin
      if (secure_mode)              why = GATE_WAIT_SEC;
      else if (ctl_q)               why = GATE_WAIT_CTL;
      else if (pred_q[ld_req_slot]) why = GATE_WAIT_PRED;
      else                          why = GATE_FREE;
   end

   assign issue_ok = ld_req_v && live_q[ld_req_slot] && !issued_q[ld_req_slot] &&
                     (why == GATE_FREE || !unres_sel);

   for (genvar l = 0; l < LD_N; l++) begin : g_fire
      assign fire[l] = issue_ok && (ld_req_slot == LIW'(l));
   end

   sbg_alias_match #(.LD_N(LD_N), .AW(AW), .GRAN(GRAN)) u_am (
      .res_v(st_res_v), .res_addr(st_res_addr),
      .live(live_q), .issued(issued_q), .fire(fire), .snap_hit(snap_hit),
      .laddr(laddr_q), .req_addr(ld_req_addr), .hit(hit)
   );

   sbg_replay_pick #(.LD_N(LD_N)) u_pk (
      .pend(pend_q), .valid(replay_v), .idx(replay_slot), .clr(clr)
   );

   for (genvar l = 0; l < LD_N; l++) begin : g_slot
      localparam logic [LIW-1:0] MY = LIW'(l);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pred_q[l] <= 1'b0;
         end else if (clr[l]) begin
            pred_q[l] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q[l]   <= 1'b0;
            issued_q[l] <= 1'b0;
            pend_q[l]   <= 1'b0;
            snap_q[l]   <= '0;
            laddr_q[l]  <= '0;
         end else if (ld_free_v && ld_free_slot == MY) begin
            live_q[l]   <= 1'b0;
            issued_q[l] <= 1'b0;
            pend_q[l]   <= 1'b0;
            snap_q[l]   <= '0;
         end else if (ld_disp_v && ld_disp_slot == MY) begin
            live_q[l]   <= 1'b1;
            issued_q[l] <= 1'b0;
            pend_q[l]   <= 1'b0;
            snap_q[l]   <= st_valid & ~ret_mask;
         end else begin
            snap_q[l] <= snap_q[l] & ~ret_mask;
            if (clr[l]) begin
               pend_q[l]   <= 1'b0;
               issued_q[l] <= 1'b0;
            end else begin
               if (fire[l]) begin
                  issued_q[l] <= 1'b1;
                  laddr_q[l]  <= ld_req_addr;
               end
               if (hit[l]) pend_q[l] <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sbg_gate_chk.sv
module sbg_gate_chk #(
   parameter int LD_N = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ctl_q,
   input logic                    secure_mode,
   input logic                    unres_sel,
   input logic                    issue_ok,
   input logic                    replay_v,
   input logic [$clog2(LD_N)-1:0] replay_slot,
   input logic [LD_N-1:0]         pred_q
);

   // R1: first cycle out of reset sees the control bit clear
   a_r1_ctl_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !ctl_q);

   // R3: control bit blocks while an older store is unresolved
   a_r3_ctl_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q && unres_sel) |-> !issue_ok);

   // R4: secure mode blocks while an older store is unresolved
   a_r4_secure_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (secure_mode && unres_sel) |-> !issue_ok);

   // R6: one replay pulse per slot, never the same slot two cycles running
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      replay_v |=> !(replay_v && replay_slot == $past(replay_slot)));

   // R8: the replayed slot's predictor turns to alias
   a_r8_pred_set: assert property (@(posedge clk) disable iff (!rst_n)
      replay_v |=> pred_q[$past(replay_slot)]);

endmodule

bind spec_load_gate sbg_gate_chk #(.LD_N(LD_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .secure_mode(secure_mode),
   .unres_sel(unres_sel), .issue_ok(issue_ok), .replay_v(replay_v),
   .replay_slot(replay_slot), .pred_q(pred_q)
);

// File: tb/sim_spec_load_gate.sv
module sim_spec_load_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 0, ctl_wd = 0, secure_mode = 0;
   logic        st_alloc_v = 0, st_res_v = 0, st_ret_v = 0;
   logic [2:0]  st_alloc_idx = 0, st_res_idx = 0, st_ret_idx = 0;
   logic [31:0] st_res_addr = 0, ld_req_addr = 0;
   logic        ld_disp_v = 0, ld_req_v = 0, ld_free_v = 0;
   logic [1:0]  ld_disp_slot = 0, ld_req_slot = 0, ld_free_slot = 0;
   logic        issue_ok, replay_v;
   logic [1:0]  replay_slot;

   always #5 clk = ~clk;

   spec_load_gate u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(ctl_wd),
      .secure_mode(secure_mode),
      .st_alloc_v(st_alloc_v), .st_alloc_idx(st_alloc_idx),
      .st_res_v(st_res_v), .st_res_idx(st_res_idx), .st_res_addr(st_res_addr),
      .st_ret_v(st_ret_v), .st_ret_idx(st_ret_idx),
      .ld_disp_v(ld_disp_v), .ld_disp_slot(ld_disp_slot),
      .ld_req_v(ld_req_v), .ld_req_slot(ld_req_slot), .ld_req_addr(ld_req_addr),
      .ld_free_v(ld_free_v), .ld_free_slot(ld_free_slot),
      .issue_ok(issue_ok), .replay_v(replay_v), .replay_slot(replay_slot)
   );

   // Reference state kept from the requirements
   bit        m_ctl;
   bit [7:0]  m_sv, m_sk;
   bit [3:0]  m_live, m_iss, m_pred, m_pend;
   bit [7:0]  m_snap [4];
   bit [31:0] m_la [4];

   int    n_run = 0, n_fail = 0;
   bit    done = 0;
   string dtag = "";

   task automatic chk(bit good, string tag, string what, int act, int exp);
      n_run++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic void model_reset();
      m_ctl = 0; m_sv = 0; m_sk = 0; m_live = 0; m_iss = 0; m_pred = 0; m_pend = 0;
      for (int l = 0; l < 4; l++) begin m_snap[l] = 0; m_la[l] = 0; end
   endfunction

   function automatic bit exp_ok();
      int s;
      bit unres, strict_w;
      if (!ld_req_v) return 0;
      s = int'(ld_req_slot);
      if (!m_live[s] || m_iss[s]) return 0;
      unres    = |(m_snap[s] & m_sv & ~m_sk);
      strict_w = m_ctl | secure_mode | m_pred[s];
      return !(strict_w && unres);
   endfunction

   function automatic int low_pend();
      for (int l = 0; l < 4; l++) if (m_pend[l]) return l;
      return -1;
   endfunction

   function automatic bit same_blk(bit [31:0] a, bit [31:0] b);
      return (a >> 3) == (b >> 3);
   endfunction

   function automatic void model_edge(bit ok, int sel);
      bit [7:0] retm;
      bit       hit, clr;
      retm = 0;
      if (st_ret_v) retm[st_ret_idx] = 1;
      for (int l = 0; l < 4; l++) begin
         hit = st_res_v && m_snap[l][st_res_idx] && m_live[l] &&
               ((m_iss[l] && same_blk(m_la[l], st_res_addr)) ||
                (ok && int'(ld_req_slot) == l && same_blk(ld_req_addr, st_res_addr)));
         clr = (sel == l);
         if (clr) m_pred[l] = 1;
         if (ld_free_v && int'(ld_free_slot) == l) begin
            m_live[l] = 0; m_iss[l] = 0; m_pend[l] = 0; m_snap[l] = 0;
         end else if (ld_disp_v && int'(ld_disp_slot) == l) begin
            m_live[l] = 1; m_iss[l] = 0; m_pend[l] = 0; m_snap[l] = m_sv & ~retm;
         end else begin
            m_snap[l] = m_snap[l] & ~retm;
            if (clr) begin
               m_pend[l] = 0; m_iss[l] = 0;
            end else begin
               if (ok && int'(ld_req_slot) == l) begin m_iss[l] = 1; m_la[l] = ld_req_addr; end
               if (hit) m_pend[l] = 1;
            end
         end
      end
      for (int s = 0; s < 8; s++) begin
         if (retm[s]) begin m_sv[s] = 0; m_sk[s] = 0; end
         else if (st_alloc_v && int'(st_alloc_idx) == s) begin m_sv[s] = 1; m_sk[s] = 0; end
         else if (st_res_v && int'(st_res_idx) == s) m_sk[s] = 1;
      end
      if (ctl_we) m_ctl = ctl_wd;
   endfunction

   task automatic clear_pulses();
      ctl_we = 0; st_alloc_v = 0; st_res_v = 0; st_ret_v = 0;
      ld_disp_v = 0; ld_req_v = 0; ld_free_v = 0;
   endtask

   // Inputs are set just after a falling edge; outputs are compared 4 ns later
   task automatic step();
      bit    e_ok;
      int    sel;
      string ti, tr;
      #4;
      e_ok = exp_ok();
      sel  = low_pend();
      if (dtag != "") begin ti = dtag; tr = dtag; end
      else begin
         tr = "R6";
         if (secure_mode) ti = "R4";
         else if (m_ctl) ti = "R3";
         else if (ld_req_v && m_pred[ld_req_slot]) ti = "R8";
         else ti = "R2";
      end
      chk(issue_ok == e_ok, ti, "issue_ok", int'(issue_ok), int'(e_ok));
      chk(replay_v == (sel >= 0), tr, "replay_v", int'(replay_v), int'(sel >= 0));
      if (sel >= 0) chk(int'(replay_slot) == sel, (dtag != "") ? dtag : "R9",
                        "replay_slot", int'(replay_slot), sel);
      model_edge(e_ok, sel);
      @(posedge clk);
      @(negedge clk);
      clear_pulses();
   endtask

   task automatic do_reset();
      rst_n = 0; secure_mode = 0;
      clear_pulses();
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1;
   endtask

   function automatic int pick(bit [7:0] mask, int n);
      int i;
      for (int k = 0; k < 32; k++) begin
         i = int'($urandom % n);
         if (mask[i]) return i;
      end
      return -1;
   endfunction

   initial begin
      #1ms;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int f, r, d, q, a, e;
      void'($urandom(32'h5eed_1234));
      model_reset();
      @(negedge clk);
      do_reset();

      // R1: idle and empty slots after reset
      dtag = "R1";
      step();
      ld_req_v = 1; ld_req_slot = 0; ld_req_addr = 32'h40; step();

      // R2: speculative issue past an unresolved older store
      dtag = "R2";
      st_alloc_v = 1; st_alloc_idx = 0; step();
      ld_disp_v = 1; ld_disp_slot = 0; step();
      ld_req_v = 1; ld_req_slot = 0; ld_req_addr = 32'h40; step();

      // R7 and R6: late alias differing only in the low three bits
      dtag = "R7";
      st_res_v = 1; st_res_idx = 0; st_res_addr = 32'h44; step();
      step();
      dtag = "R6";
      step();

      // R8: the replayed slot now waits for older stores
      dtag = "R8";
      st_ret_v = 1; st_ret_idx = 0; st_alloc_v = 1; st_alloc_idx = 1;
      ld_free_v = 1; ld_free_slot = 0; step();
      ld_disp_v = 1; ld_disp_slot = 0; step();
      ld_req_v = 1; ld_req_slot = 0; ld_req_addr = 32'h80; step();
      st_res_v = 1; st_res_idx = 1; st_res_addr = 32'h180; step();
      ld_req_v = 1; ld_req_slot = 0; ld_req_addr = 32'h80; step();
      st_ret_v = 1; st_ret_idx = 1; step();

      // R12 and R3: control bit written, then blocks
      dtag = "R12";
      ctl_we = 1; ctl_wd = 1; st_alloc_v = 1; st_alloc_idx = 2; step();
      dtag = "R3";
      ld_disp_v = 1; ld_disp_slot = 1; step();
      ld_req_v = 1; ld_req_slot = 1; ld_req_addr = 32'h200; step();
      st_res_v = 1; st_res_idx = 2; st_res_addr = 32'h208; step();
      ld_req_v = 1; ld_req_slot = 1; ld_req_addr = 32'h200; step();
      ctl_we = 1; ctl_wd = 0; step();

      // R4: secure mode blocks with the control bit clear
      dtag = "R4";
      secure_mode = 1; st_alloc_v = 1; st_alloc_idx = 3; step();
      ld_disp_v = 1; ld_disp_slot = 2; step();
      ld_req_v = 1; ld_req_slot = 2; ld_req_addr = 32'h300; step();
      secure_mode = 0;
      ld_req_v = 1; ld_req_slot = 2; ld_req_addr = 32'h300; step();

      // R5: a younger store neither blocks nor replays
      dtag = "R5";
      ld_disp_v = 1; ld_disp_slot = 3; step();
      st_alloc_v = 1; st_alloc_idx = 4; step();
      ld_req_v = 1; ld_req_slot = 3; ld_req_addr = 32'h300; step();
      st_res_v = 1; st_res_idx = 4; st_res_addr = 32'h300; step();
      step();

      // R9: two pending replays, lowest slot first
      dtag = "R9";
      st_res_v = 1; st_res_idx = 3; st_res_addr = 32'h304; step();
      step(); step(); step();

      // R10: retired then reallocated entry leaves old snapshot
      dtag = "R10";
      ld_free_v = 1; ld_free_slot = 1; step();
      ctl_we = 1; ctl_wd = 1; st_alloc_v = 1; st_alloc_idx = 5; step();
      ld_disp_v = 1; ld_disp_slot = 1; step();
      ld_req_v = 1; ld_req_slot = 1; ld_req_addr = 32'h600; step();
      st_ret_v = 1; st_ret_idx = 5; step();
      st_alloc_v = 1; st_alloc_idx = 5; step();
      ld_req_v = 1; ld_req_slot = 1; ld_req_addr = 32'h600; step();
      ctl_we = 1; ctl_wd = 0; step();

      // R11: issue and overlapping resolve in one cycle
      dtag = "R11";
      ld_free_v = 1; ld_free_slot = 1; st_alloc_v = 1; st_alloc_idx = 6; step();
      ld_disp_v = 1; ld_disp_slot = 1; step();
      ld_req_v = 1; ld_req_slot = 1; ld_req_addr = 32'h500;
      st_res_v = 1; st_res_idx = 6; st_res_addr = 32'h503; step();
      step(); step();

      // Constrained random phase
      dtag = "";
      for (int it = 0; it < 4000; it++) begin
         if (it % 600 == 0) begin do_reset(); end
         if ($urandom % 50 == 0) begin ctl_we = 1; ctl_wd = 1'($urandom % 2); end
         secure_mode = ($urandom % 8 == 0);
         a = ($urandom % 3 == 0) ? pick(~m_sv, 8) : -1;
         if (a >= 0) begin st_alloc_v = 1; st_alloc_idx = 3'(a); end
         r = pick(m_sv & ~m_sk, 8);
         if (r >= 0 && $urandom % 2 == 0) begin
            st_res_v = 1; st_res_idx = 3'(r); st_res_addr = $urandom % 64;
         end
         e = ($urandom % 4 == 0) ? pick(m_sv & m_sk, 8) : -1;
         if (e >= 0) begin st_ret_v = 1; st_ret_idx = 3'(e); end
         d = ($urandom % 3 == 0) ? pick({4'b0, ~m_live}, 4) : -1;
         if (d >= 0) begin ld_disp_v = 1; ld_disp_slot = 2'(d); end
         q = ($urandom % 2 == 0) ? int'($urandom % 4) : -1;
         if (q >= 0) begin ld_req_v = 1; ld_req_slot = 2'(q); ld_req_addr = $urandom % 64; end
         f = ($urandom % 6 == 0) ? pick({4'b0, m_live}, 4) : -1;
         if (f >= 0 && f != q) begin ld_free_v = 1; ld_free_slot = 2'(f); end
         step();
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule